// File: doc/BRIEF.md
# Two-Wire Wiper Potentiometer Command Slave

This block is the serial command front end of a digitally controlled resistor. It watches a two-wire bus (SCL, SDA) with a fast system clock, finds START and STOP conditions, and then decodes a device identification byte and an instruction byte. The identification byte must carry the device-type code and match three strap pins. The block holds sixteen 8-bit data registers in four banks of four, and one 8-bit wiper counter register whose value is presented as the wiper code output.

Commands read or write the wiper, read or write any data register, or move a value between a bank-0 data register and the wiper. A data-register write and a wiper-to-register transfer stand in for non-volatile stores. When the STOP that closes such a command arrives, a write-busy timer starts. While it runs, the slave ignores the bus completely, so a host that sends START plus the device address gets no acknowledge until the store is done. This is how the host polls for completion. The SDA output is open-drain: the block only ever pulls the line low.

Top module: `potslv_top`

## Requirements
- R1: After reset the wiper register reads 0x80, all sixteen data registers read 0x00, and SDA is released.
- R2: The identification byte is acknowledged when bits [7:4] equal 0101 and bits [3:1] equal the address pins. Bit 0 is ignored. The acknowledge is SDA held low through the ninth SCL high phase.
- R3: An identification byte with a wrong type code or a wrong address gets no acknowledge, and the bytes that follow it up to the next START or STOP change nothing.
- R4: Instruction byte layout: bits [7:5] opcode, bits [4:3] bank, bits [2:1] register within the bank, bit 0 pot select. A pot select of 1 gets no acknowledge and has no effect.
- R5: Opcode 1 writes the following data byte into the wiper, which appears on the wiper output. Opcode 0 returns the wiper value as a read byte.
- R6: Opcode 3 writes the following data byte into data register {bank, register}, and opcode 2 reads it back. All sixteen registers hold independent values.
- R7: Opcodes 4 and 6 copy a data register into the wiper, and opcode 5 copies the wiper into a data register. Each acts when its instruction is acknowledged. With a non-zero bank these opcodes get no acknowledge and change nothing.
- R8: Opcode 7 (increment/decrement) gets no acknowledge and has no effect.
- R9: A read byte is driven MSB first, with SDA changing only while SCL is low. SDA is released during the ninth clock, which carries the host's acknowledge.
- R10: A STOP that ends an acknowledged opcode 3 or opcode 5 starts a busy window of BUSY_CYCLES system clocks. During the window, START plus a matching identification byte gets no acknowledge. After the window, the slave acknowledges again. Other commands start no busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| addr_pins | input | 3 | Strap pins compared with identification bits [3:1] |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain), 0 releases it |
| wiper_o | output | 8 | Wiper counter register value |

## Verification
Two things can coincide: the busy window expiring, and a host polling START with its identification byte. The bench provokes this by sending back-to-back polls right after each store. It timestamps every poll START against the closing STOP, and it judges each poll's acknowledge by whether that START fell inside or outside BUSY_CYCLES, with a margin of a few synchronizer cycles. A second overlap is a transfer opcode writing the wiper at the same acknowledge edge where the instruction is decoded. For that case the bench checks the wiper output after the transfer against its own register model, and also checks that a non-zero bank leaves the wiper untouched.

// File: rtl/potslv_pkg.sv
// Package: shared constants and types for the two-wire potentiometer slave.
// Assumes 8-bit bus bytes and a 3-bit opcode field in the instruction byte.
package potslv_pkg;

    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_TYPE = 4'b0101;

    typedef enum logic [2:0] {
        OP_RD_WIPER      = 3'd0,
        OP_WR_WIPER      = 3'd1,
        OP_RD_DREG       = 3'd2,
        OP_WR_DREG       = 3'd3,
        OP_DREG_TO_WIPER = 3'd4,
        OP_WIPER_TO_DREG = 3'd5,
        OP_GLOBAL_XFER   = 3'd6,
        OP_STEP          = 3'd7
    } pot_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ID,
        ST_INSTR,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } link_state_e;

endpackage

// File: rtl/potslv_sync.sv
// Module: potslv_sync
// Brings SCL and SDA into the system clock domain through a flop chain and
// produces one-cycle pulses for SCL edges and for START/STOP conditions.
// Assumes the bus is at least several system clocks per SCL phase.
module potslv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    // Synchronizer chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_sh[STAGES-1];
            sda_q  <= sda_sh[STAGES-1];
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        scl_s     = scl_sh[STAGES-1];
        sda_s     = sda_sh[STAGES-1];
        scl_lvl   = scl_s;
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_evt = scl_s & scl_q & sda_q & ~sda_s;
        stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/potslv_regfile.sv
// Module: potslv_regfile
// Banked data register file plus the wiper counter register. One write port
// and one combinational read port for the data registers; the wiper has its
// own write port. Assumes at most one data-register write per cycle.
module potslv_regfile #(
    parameter int                       WIDTH    = 8,
    parameter int                       BANKS    = 4,
    parameter int                       PER_BANK = 4,
    parameter logic [WIDTH-1:0]         WIPER_RST = 8'h80
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    dr_we,
    input  logic [$clog2(BANKS*PER_BANK)-1:0]       dr_waddr,
    input  logic [WIDTH-1:0]                        dr_wdata,
    input  logic [$clog2(BANKS*PER_BANK)-1:0]       dr_raddr,
    output logic [WIDTH-1:0]                        dr_rdata,
    input  logic                                    wp_we,
    input  logic [WIDTH-1:0]                        wp_wdata,
    output logic [WIDTH-1:0]                        wiper
);

    localparam int NREG = BANKS * PER_BANK;
    localparam int AW   = $clog2(NREG);

    logic [WIDTH-1:0] dreg [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_dreg
        // One data register: cleared on reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                dreg[g] <= '0;
            else if (dr_we && dr_waddr == AW'(g))
                dreg[g] <= dr_wdata;
        end
    end

    // Read port.
    always_comb dr_rdata = dreg[dr_raddr];

    // Wiper counter register, mid-scale after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wiper <= WIPER_RST;
        else if (wp_we)
            wiper <= wp_wdata;
    end

    // R1
    wiper_rst_chk: assert property (@(posedge clk) !rst_n |=> wiper == WIPER_RST);

endmodule

// File: rtl/potslv_busy.sv
// Module: potslv_busy
// Write-busy timer standing in for a non-volatile store. A start pulse loads
// the count; busy stays high until the count reaches zero.
module potslv_busy #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    // Down counter loaded by start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Busy flag from the counter.
    always_comb busy = (cnt != '0);

    // R10
    busy_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(CYCLES));

endmodule

// File: rtl/potslv_top.sv
// Module: potslv_top
// Two-wire command slave for a single-wiper potentiometer. Decodes an
// identification byte and an instruction byte, runs data writes and reads,
// bank-0 transfers, and a busy window after non-volatile stores during which
// the bus is ignored. Assumes SCL is slow relative to clk.
module potslv_top #(
    parameter int BUSY_CYCLES = 2000,
    parameter int SYNC_STAGES = 2,
    parameter int BANKS       = 4,
    parameter int PER_BANK    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] addr_pins,
    output logic       sda_pull_o,
    output logic [7:0] wiper_o
);

    import potslv_pkg::*;

    localparam int AW = $clog2(BANKS * PER_BANK);
    localparam int BW = $clog2(BANKS);
    localparam int RW = $clog2(PER_BANK);

    logic scl_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic busy, busy_start;

    link_state_e        state, next_q;
    logic [3:0]         bitcnt;
    logic [BYTE_W-1:0]  shreg;
    logic [BYTE_W-1:0]  rd_byte;
    pot_op_e            op_q;
    logic [AW-1:0]      addr_q;
    logic               pull;
    logic               nv_pend;

    logic               id_ok, ins_ok, ins_xfer, at_ackfall;
    pot_op_e            ins_op;
    logic [BW-1:0]      ins_bank;
    logic [RW-1:0]      ins_idx;
    logic               ins_p0;
    logic [AW-1:0]      ins_addr;

    logic               dr_we, wp_we;
    logic [AW-1:0]      dr_waddr, dr_raddr;
    logic [BYTE_W-1:0]  dr_wdata, dr_rdata, wp_wdata, wiper;

    potslv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    potslv_regfile #(
        .WIDTH    (BYTE_W),
        .BANKS    (BANKS),
        .PER_BANK (PER_BANK),
        .WIPER_RST(8'h80)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .dr_we    (dr_we),
        .dr_waddr (dr_waddr),
        .dr_wdata (dr_wdata),
        .dr_raddr (dr_raddr),
        .dr_rdata (dr_rdata),
        .wp_we    (wp_we),
        .wp_wdata (wp_wdata),
        .wiper    (wiper)
    );

    potslv_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (busy_start),
        .busy  (busy)
    );

    // Field decode of the byte just shifted in, and legality checks.
    always_comb begin
        id_ok     = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == addr_pins);
        ins_op    = pot_op_e'(shreg[7:5]);
        ins_bank  = shreg[4:3];
        ins_idx   = shreg[2:1];
        ins_p0    = shreg[0];
        ins_addr  = {ins_bank, ins_idx};
        ins_xfer  = (ins_op == OP_DREG_TO_WIPER) || (ins_op == OP_WIPER_TO_DREG) ||
                    (ins_op == OP_GLOBAL_XFER);
        ins_ok    = !ins_p0 && (ins_op != OP_STEP) && !(ins_xfer && ins_bank != '0);
        at_ackfall = scl_fall && (bitcnt == 4'd8);
    end

    // Register file strobes, issued at the falling edge that opens the ACK bit.
    always_comb begin
        dr_we    = at_ackfall &&
                   ((state == ST_INSTR && ins_ok && ins_op == OP_WIPER_TO_DREG) ||
                    (state == ST_WDATA && op_q == OP_WR_DREG));
        wp_we    = at_ackfall &&
                   ((state == ST_INSTR && ins_ok &&
                     (ins_op == OP_DREG_TO_WIPER || ins_op == OP_GLOBAL_XFER)) ||
                    (state == ST_WDATA && op_q == OP_WR_WIPER));
        dr_waddr = (state == ST_INSTR) ? ins_addr : addr_q;
        dr_raddr = ins_addr;
        dr_wdata = (state == ST_INSTR) ? wiper : shreg;
        wp_wdata = (state == ST_INSTR) ? dr_rdata : shreg;
        busy_start = stop_evt && nv_pend;
        sda_pull_o = pull;
        wiper_o    = wiper;
    end

    // Bus protocol engine: byte shifting, ACK generation and command sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            next_q  <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            rd_byte <= '0;
            op_q    <= OP_RD_WIPER;
            addr_q  <= '0;
            pull    <= 1'b0;
            nv_pend <= 1'b0;
        end else if (start_evt) begin
            pull   <= 1'b0;
            bitcnt <= '0;
            state  <= busy ? ST_IDLE : ST_ID;
        end else if (stop_evt) begin
            pull    <= 1'b0;
            bitcnt  <= '0;
            state   <= ST_IDLE;
            nv_pend <= 1'b0;
        end else if (state != ST_IDLE && state != ST_SKIP) begin
            if (scl_rise) begin
                if (bitcnt < 4'd8) begin
                    bitcnt <= bitcnt + 1'b1;
                    if (state != ST_RDATA)
                        shreg <= {shreg[BYTE_W-2:0], sda_i};
                end else begin
                    bitcnt <= 4'd9;
                end
            end
            if (scl_fall) begin
                if (state == ST_RDATA) begin
                    if (bitcnt >= 4'd1 && bitcnt <= 4'd7)
                        pull <= ~rd_byte[3'(7 - bitcnt)];
                    else if (bitcnt == 4'd8)
                        pull <= 1'b0;
                    else if (bitcnt == 4'd9) begin
                        bitcnt <= '0;
                        state  <= ST_SKIP;
                    end
                end else if (bitcnt == 4'd8) begin
                    case (state)
                        ST_ID: begin
                            pull   <= id_ok;
                            next_q <= id_ok ? ST_INSTR : ST_SKIP;
                        end
                        ST_INSTR: begin
                            pull    <= ins_ok;
                            op_q    <= ins_op;
                            addr_q  <= ins_addr;
                            rd_byte <= (ins_op == OP_RD_WIPER) ? wiper : dr_rdata;
                            if (ins_ok && ins_op == OP_WIPER_TO_DREG)
                                nv_pend <= 1'b1;
                            if (!ins_ok)
                                next_q <= ST_SKIP;
                            else if (ins_op == OP_RD_WIPER || ins_op == OP_RD_DREG)
                                next_q <= ST_RDATA;
                            else if (ins_op == OP_WR_WIPER || ins_op == OP_WR_DREG)
                                next_q <= ST_WDATA;
                            else
                                next_q <= ST_SKIP;
                        end
                        default: begin
                            pull   <= 1'b1;
                            next_q <= ST_SKIP;
                            if (op_q == OP_WR_DREG)
                                nv_pend <= 1'b1;
                        end
                    endcase
                end else if (bitcnt == 4'd9) begin
                    bitcnt <= '0;
                    state  <= next_q;
                    pull   <= (next_q == ST_RDATA) ? ~rd_byte[BYTE_W-1] : 1'b0;
                end
            end
        end
    end

    // R10
    busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt));

    // R10
    quiet_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull_o);

    // R9
    pull_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> $past(!scl_lvl));

    // R7
    wiper_via_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper_o) |-> $past(wp_we));

endmodule

// File: tb/potslv_top_tb.sv
// Bench for potslv_top: bus master tasks with a wired-AND SDA, a register
// model, directed corner cases and seeded random register traffic.
module potslv_top_tb;

    localparam int BUSY = 2000;
    localparam int Q    = 10;
    localparam logic [2:0] MY_ADDR = 3'b101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       pull;
    logic [7:0] wiper;
    wire        sda_bus = sda_m & ~pull;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int t_start = 0;
    int t_stop  = 0;
    logic [7:0] m_dr [16];
    logic [7:0] m_wiper;

    potslv_top #(.BUSY_CYCLES(BUSY)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .addr_pins  (MY_ADDR),
        .sda_pull_o (pull),
        .wiper_o    (wiper)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    function automatic logic [7:0] id_byte(input logic [3:0] typ, input logic [2:0] a, input logic b0);
        return {typ, a, b0};
    endfunction

    function automatic logic [7:0] ins_byte(input int op, input int bank, input int idx, input logic p0);
        return {3'(op), 2'(bank), 2'(idx), p0};
    endfunction

    function automatic logic exp_ins_ack(input int op, input int bank, input logic p0);
        return !p0 && op != 7 && !((op >= 4 && op <= 6) && bank != 0);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
        sda_m = 1'b0; t_start = cyc; w(Q);
        scl_m = 1'b0; w(Q/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q);
        sda_m = 1'b1; w(Q); t_stop = cyc;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; w(Q); scl_m = 1'b1; w(Q); scl_m = 1'b0; w(Q/2);
        end
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q/2);
        ack = ~sda_bus; w(Q/2); scl_m = 1'b0; w(Q/2);
    endtask

    task automatic recv_byte(output logic [7:0] b, output logic released);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            w(Q); scl_m = 1'b1; w(Q/2); b[i] = sda_bus; w(Q/2); scl_m = 1'b0;
        end
        w(Q); scl_m = 1'b1; w(Q/2); released = sda_bus; w(Q/2); scl_m = 1'b0; w(Q/2);
    endtask

    // Full command; cont sends all bytes even after a missing ACK.
    task automatic cmd_write(input logic [7:0] idb, input logic [7:0] inb, input bit has_data,
                             input logic [7:0] data, input bit cont,
                             output logic a_id, output logic a_in, output logic a_d);
        a_in = 1'b0; a_d = 1'b0;
        bus_start();
        send_byte(idb, a_id);
        if (a_id || cont) begin
            send_byte(inb, a_in);
            if (has_data && (a_in || cont)) send_byte(data, a_d);
        end
        bus_stop();
    endtask

    task automatic cmd_read(input int op, input int bank, input int idx,
                            output logic [7:0] data, output logic rel, output logic a_in);
        logic a_id;
        data = 'x; rel = 1'b1; a_in = 1'b0;
        bus_start();
        send_byte(id_byte(4'b0101, MY_ADDR, 1'b0), a_id);
        if (a_id) begin
            send_byte(ins_byte(op, bank, idx, 1'b0), a_in);
            if (a_in) recv_byte(data, rel);
        end
        bus_stop();
    endtask

    task automatic poll(output logic ack);
        bus_start();
        send_byte(id_byte(4'b0101, MY_ADDR, 1'b0), ack);
        bus_stop();
    endtask

    // Poll until ACK, judging every poll against the busy window.
    task automatic wait_ready(input string req, input bit timed);
        logic ack;
        int   ref_stop = t_stop;
        for (int k = 0; k < 40; k++) begin
            poll(ack);
            if (timed) begin
                chk(req, ack, (t_start - ref_stop) > BUSY + 2*Q);
            end
            if (ack) return;
        end
        chk(req, 0, 1);
    endtask

    task automatic check_dr(input string req, input int a);
        logic [7:0] d; logic rel, ain;
        cmd_read(2, a / 4, a % 4, d, rel, ain);
        chk(req, d, m_dr[a]);
    endtask

    initial begin
        logic a_id, a_in, a_d, rel, ack;
        logic [7:0] d;
        void'($urandom(32'h5EED_0017));
        for (int i = 0; i < 16; i++) m_dr[i] = 8'h00;
        m_wiper = 8'h80;
        w(5);
        rst_n = 1'b1;
        w(5);

        // R1 reset state
        chk("R1 wiper", wiper, 8'h80);
        chk("R1 sda", pull, 1'b0);
        check_dr("R1 dreg", 11);

        // R5 wiper write then read, MSB-first pattern (R9)
        cmd_write(id_byte(4'b0101, MY_ADDR, 1'b0), ins_byte(1, 0, 0, 1'b0), 1, 8'h35, 0, a_id, a_in, a_d);
        m_wiper = 8'h35;
        chk("R2 id ack", a_id, 1);
        chk("R5 data ack", a_d, 1);
        chk("R5 wiper_o", wiper, m_wiper);
        cmd_read(0, 0, 0, d, rel, a_in);
        chk("R9 msb first", d, 8'h35);
        chk("R9 release", rel, 1'b1);
        poll(ack);
        chk("R10 no busy after wiper write", ack, 1);

        // R2 bit 0 ignored
        cmd_write(id_byte(4'b0101, MY_ADDR, 1'b1), ins_byte(1, 0, 0, 1'b0), 1, 8'h62, 0, a_id, a_in, a_d);
        m_wiper = 8'h62;
        chk("R2 bit0 ignored", a_id, 1);
        chk("R2 wiper", wiper, m_wiper);

        // R3 wrong address and wrong type; rest of frame ignored
        cmd_write(id_byte(4'b0101, 3'b100, 1'b0), ins_byte(1, 0, 0, 1'b0), 1, 8'h01, 1, a_id, a_in, a_d);
        chk("R3 addr nack", a_id, 0);
        chk("R3 ins ignored", a_in, 0);
        chk("R3 wiper kept", wiper, m_wiper);
        cmd_write(id_byte(4'b0110, MY_ADDR, 1'b0), ins_byte(1, 0, 0, 1'b0), 1, 8'h02, 1, a_id, a_in, a_d);
        chk("R3 type nack", a_id, 0);
        chk("R3 wiper kept2", wiper, m_wiper);

        // R4 pot select 1
        cmd_write(id_byte(4'b0101, MY_ADDR, 1'b0), ins_byte(1, 0, 0, 1'b1), 1, 8'h03, 1, a_id, a_in, a_d);
        chk("R4 p0 nack", a_in, exp_ins_ack(1, 0, 1'b1));
        chk("R4 wiper kept", wiper, m_wiper);

        // R8 increment/decrement
        cmd_write(id_byte(4'b0101, MY_ADDR, 1'b0), ins_byte(7, 0, 0, 1'b0), 0, 8'h00, 0, a_id, a_in, a_d);
        chk("R8 step nack", a_in, exp_ins_ack(7, 0, 1'b0));
        chk("R8 wiper kept", wiper, m_wiper);

        // R6 + R10 data register write with timed polling
        cmd_write(id_byte(4'b0101, MY_ADDR, 1'b0), ins_byte(3, 0, 1, 1'b0), 1, 8'hA5, 0, a_id, a_in, a_d);
        m_dr[1] = 8'hA5;
        chk("R6 write ack", a_d, 1);
        wait_ready("R10 busy window", 1);
        check_dr("R6 readback", 1);

        // R7 transfer register to wiper, no busy after it
        cmd_write(id_byte(4'b0101, MY_ADDR, 1'b0), ins_byte(4, 0, 1, 1'b0), 0, 8'h00, 0, a_id, a_in, a_d);
        m_wiper = m_dr[1];
        chk("R7 xfer ack", a_in, 1);
        chk("R7 wiper from dreg", wiper, m_wiper);
        poll(ack);
        chk("R10 no busy after xfer", ack, 1);

        // R7 non-zero bank rejected
        cmd_write(id_byte(4'b0101, MY_ADDR, 1'b0), ins_byte(1, 0, 0, 1'b0), 1, 8'h44, 0, a_id, a_in, a_d);
        m_wiper = 8'h44;
        cmd_write(id_byte(4'b0101, MY_ADDR, 1'b0), ins_byte(4, 2, 1, 1'b0), 0, 8'h00, 0, a_id, a_in, a_d);
        chk("R7 bank nack", a_in, exp_ins_ack(4, 2, 1'b0));
        chk("R7 bank wiper kept", wiper, m_wiper);
        cmd_write(id_byte(4'b0101, MY_ADDR, 1'b0), ins_byte(5, 3, 0, 1'b0), 0, 8'h00, 0, a_id, a_in, a_d);
        chk("R7 bank nack wtod", a_in, 0);
        poll(ack);
        chk("R10 no busy after rejected store", ack, 1);

        // R7 wiper to register (store, starts busy)
        cmd_write(id_byte(4'b0101, MY_ADDR, 1'b0), ins_byte(5, 0, 2, 1'b0), 0, 8'h00, 0, a_id, a_in, a_d);
        m_dr[2] = m_wiper;
        chk("R7 wtod ack", a_in, 1);
        wait_ready("R10 busy after wtod", 1);
        check_dr("R7 wtod value", 2);
        check_dr("R3 bank3 untouched", 12);

        // R7 global transfer
        cmd_write(id_byte(4'b0101, MY_ADDR, 1'b0), ins_byte(6, 0, 1, 1'b0), 0, 8'h00, 0, a_id, a_in, a_d);
        m_wiper = m_dr[1];
        chk("R7 global wiper", wiper, m_wiper);

        // R6 random traffic across all banks
        for (int it = 0; it < 14; it++) begin
            int a = $urandom_range(0, 15);
            logic [7:0] v = 8'($urandom);
            if ($urandom_range(0, 3) == 0) begin
                cmd_write(id_byte(4'b0101, MY_ADDR, 1'b0), ins_byte(1, 0, 0, 1'b0), 1, v, 0, a_id, a_in, a_d);
                m_wiper = v;
                chk("R5 rand wiper", wiper, m_wiper);
            end else begin
                cmd_write(id_byte(4'b0101, MY_ADDR, 1'b0), ins_byte(3, a / 4, a % 4, 1'b0), 1, v, 0, a_id, a_in, a_d);
                m_dr[a] = v;
                chk("R6 rand ack", a_d, 1);
                wait_ready("R10 rand busy", 0);
            end
        end
        for (int a = 0; a < 16; a++) check_dr("R6 rand dreg", a);
        cmd_read(0, 0, 0, d, rel, a_in);
        chk("R5 rand read wiper", d, m_wiper);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule